// File: doc/BRIEF.md
# Descriptor-Chained Byte DMA Channel

This block is one byte-wide DMA channel that moves data between a serial-style peripheral and memory by walking a chain of 8-byte descriptors. Software writes a list pointer and a small control word, and the channel then runs on its own. It reads one descriptor at a time and, for a buffer descriptor, moves bytes whenever the peripheral raises its data request. When the buffer ends, the channel writes completion information back into the descriptor and moves on to the next one. A link descriptor redirects the walk to another list, and an end descriptor stops the channel.

A buffer ends in one of two ways. If its byte count runs down to zero, the channel marks the descriptor "completed, no status". If the peripheral raises its terminate line, the channel stores the remaining count in the descriptor and then writes a "completed, with status" byte. While that byte is written, the channel asserts a status-store strobe, and the peripheral drives six status bits into it. Each of the two completion kinds has its own rule for raising the interrupt request.

Descriptor layout (byte offsets): 0..2 buffer address, little-endian; 4 kind byte before the transfer and completion byte after it; 6..7 byte count, little-endian; 3 and 5 unused. The kind is held in kind-byte bits [1:0]: 0 plain buffer, 1 notify buffer, 2 link, 3 end.

Top module: `lldma_chan`

## Requirements
- R1: Register 0, 1 and 2 read back the list pointer as address bytes low, middle and high. Register 0 bits [2:0] always read 3'b100, so the pointer names the completion byte of the current descriptor. Pointer bits [2:0] cannot be written.
- R2: A write to register 2 while the channel is idle starts the channel. Register 3 bit 6 reads 1 while the channel is active. Writes to registers 0 to 2 while the channel is active are ignored.
- R3: Register 3 bit 2 selects the direction, 0 for peripheral to memory. In that direction each byte the channel accepts (devAck with devReq) is written to the buffer address. The address then increases by one and the count decreases by one.
- R4: If the count reaches zero and no terminate was signalled, the completion byte (offset 4) becomes 8'h80. Offsets 6..7 are not rewritten, and the channel fetches the next descriptor, 8 bytes on.
- R5: A buffer descriptor whose count is zero completes at once as in R4, with no peripheral activity.
- R6: On terminate, offsets 6 and 7 receive the remaining count, low byte first. Then offset 4 receives {2'b11, devDin[5:0]}, and devStoreStatus is high during that write.
- R7: If terminate and data request are high together, the byte is transferred first. The stored remaining count already includes that byte.
- R8: A "no status" completion sets the pending flag when register 3 bits [1:0] are 2 or 3. It also sets the flag when those bits are 1 and the descriptor is a notify buffer. With bits [1:0] at 0 it never sets the flag.
- R9: A terminated completion sets the pending flag whenever register 3 bits [1:0] are non-zero.
- R10: irq equals the pending flag, which is register 3 bit 7. Writing 1 to bit 7 clears it. If a completion sets the flag in the same cycle, the set wins.
- R11: A link descriptor loads the list pointer from its address field. An end descriptor leaves the pointer on itself and returns the channel to idle.
- R12: While memReq is high and memRdy low, memReq, memAddr and memWe stay unchanged.
- R13: With register 3 bit 2 at 1, bytes are read from the buffer in address order. Each is presented on devDout in a cycle with devAck high while devReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0..2 list pointer bytes, 3 control/status |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irq | output | 1 | Interrupt request (pending flag) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid when memRdy |
| memRdy | input | 1 | Memory access completes this cycle |
| devReq | input | 1 | Peripheral data request |
| devTerm | input | 1 | Peripheral terminate |
| devDin | input | 8 | Peripheral data to memory; bits [5:0] give status during store |
| devAck | output | 1 | Byte accepted from, or presented to, the peripheral |
| devDout | output | 8 | Byte read from memory for the peripheral |
| devStoreStatus | output | 1 | Peripheral may drive status on devDin[5:0] |

## Verification
Two things can happen in the same cycle: the channel sets the pending flag when a completion byte write finishes, and software writes 1 to register 3 bit 7 to clear that flag. The bench watches the memory port at the falling edge. When it sees the completion-byte write at offset 4 accepted with memRdy, it issues the clear write in that same cycle, so both reach the same rising edge. It then requires irq to stay high, and a later clear alone to drop it. The sweep crosses every interrupt-enable value with both buffer kinds and all three ways a buffer can end, so each interrupt decision is checked against an arithmetic prediction.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int ENTRY_BYTES = 8;

  // kind byte bits [1:0] of a fetched descriptor
  typedef enum logic [1:0] {
    ENT_BUF    = 2'd0,
    ENT_NOTIFY = 2'd1,
    ENT_LINK   = 2'd2,
    ENT_END    = 2'd3
  } entKind_t;

  typedef enum logic {
    ASEL_ENTRY = 1'b0,
    ASEL_BUF   = 1'b1
  } addrSel_t;

  typedef enum logic [2:0] {
    WD_DATA  = 3'd0,
    WD_LENLO = 3'd1,
    WD_LENHI = 3'd2,
    WD_DONE  = 3'd3,
    WD_STAT  = 3'd4
  } wdSel_t;

  localparam logic [1:0] IE_NONE   = 2'd0;
  localparam logic [1:0] IE_NOTIFY = 2'd1;
  localparam logic [1:0] CC_PLAIN  = 2'b10;
  localparam logic [1:0] CC_STAT   = 2'b11;

  localparam logic [2:0] OFS_STAT  = 3'd4;
  localparam logic [2:0] OFS_LENLO = 3'd6;
  localparam logic [2:0] OFS_LENHI = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic     fetchLd;
    logic     linkLd;
    logic     bufLd;
    logic     byteStep;
    logic     devCap;
    logic     outLd;
    logic     larStep;
    logic     irqSet;
    addrSel_t addrSel;
    logic [2:0] entOfs;
    wdSel_t   wdSel;
  } strobe_t;

endpackage

// File: rtl/lldma_dp.sv
module lldma_dp
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              active,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        devDin,
  output logic [7:0]        devDout,
  output logic              startReq,
  output entKind_t          entKind,
  output logic              entLenZero,
  output logic              lenZero,
  output logic [1:0]        ie,
  output logic              dir,
  output logic              irq
);
  localparam int LAR_W = ADDR_W - 3;

  logic [LAR_W-1:0]  lar;
  logic [ADDR_W-1:0] bar;
  logic [15:0]       blr;
  logic [7:0]        ent [ENTRY_BYTES];
  logic [7:0]        dataHold;
  logic              pend;
  logic [23:0]       larView;
  logic [23:0]       larWr;
  logic [ADDR_W-1:0] entAddr;
  logic [15:0]       entLen;
  logic              csrWr;
  logic              larWrOk;

  assign larView    = 24'({lar, 3'b100});
  assign entAddr    = ADDR_W'({ent[2], ent[1], ent[0]});
  assign entLen     = {ent[7], ent[6]};
  assign entKind    = entKind_t'(ent[4][1:0]);
  assign entLenZero = (entLen == '0);
  assign lenZero    = (blr == '0);
  assign csrWr      = regWr && (regAddr == 2'd3);
  assign larWrOk    = regWr && (regAddr != 2'd3) && !active;
  assign startReq   = larWrOk && (regAddr == 2'd2);
  assign irq        = pend;

  always_comb begin
    larWr = larView;
    case (regAddr)
      2'd0:    larWr[7:0]   = regWdata;
      2'd1:    larWr[15:8]  = regWdata;
      default: larWr[23:16] = regWdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lar      <= '0;
      bar      <= '0;
      blr      <= '0;
      dataHold <= '0;
      devDout  <= '0;
      ie       <= IE_NONE;
      dir      <= 1'b0;
      pend     <= 1'b0;
      for (int i = 0; i < ENTRY_BYTES; i++) ent[i] <= '0;
    end else begin
      if (larWrOk)        lar <= larWr[ADDR_W-1:3];
      else if (st.linkLd) lar <= entAddr[ADDR_W-1:3];
      else if (st.larStep) lar <= lar + 1'b1;

      if (st.fetchLd) ent[st.entOfs] <= memRdata;

      if (st.bufLd) begin
        bar <= entAddr;
        blr <= entLen;
      end else if (st.byteStep) begin
        bar <= bar + 1'b1;
        blr <= blr - 1'b1;
      end

      if (st.devCap) dataHold <= devDin;
      if (st.outLd)  devDout  <= memRdata;

      if (csrWr) {dir, ie} <= regWdata[2:0];

      if (st.irqSet)                 pend <= 1'b1;
      else if (csrWr && regWdata[7]) pend <= 1'b0;
    end
  end

  assign memAddr = (st.addrSel == ASEL_BUF) ? bar : {lar, st.entOfs};

  always_comb begin
    case (st.wdSel)
      WD_LENLO: memWdata = blr[7:0];
      WD_LENHI: memWdata = blr[15:8];
      WD_DONE:  memWdata = {CC_PLAIN, 6'd0};
      WD_STAT:  memWdata = {CC_STAT, devDin[5:0]};
      default:  memWdata = dataHold;
    endcase
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = larView[7:0];
      2'd1:    regRdata = larView[15:8];
      2'd2:    regRdata = larView[23:16];
      default: regRdata = {pend, active, 3'b000, dir, ie};
    endcase
  end

endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     memRdy,
  input  logic     devReq,
  input  logic     devTerm,
  input  entKind_t entKind,
  input  logic     entLenZero,
  input  logic     lenZero,
  input  logic [1:0] ie,
  input  logic     dir,
  output strobe_t  st,
  output logic     memReq,
  output logic     memWe,
  output logic     devAck,
  output logic     devStoreStatus,
  output logic     active
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_WAIT, S_MEMX, S_POST, S_WLEN0, S_WLEN1, S_WSTAT
  } state_t;

  state_t     state;
  logic [2:0] ofs;
  logic       termF;
  logic       withStat;
  logic       irqWanted;

  assign irqWanted = withStat ? (ie != IE_NONE)
                              : (ie[1] || (ie == IE_NOTIFY && entKind == ENT_NOTIFY));

  always_comb begin
    st             = '0;
    st.addrSel     = ASEL_ENTRY;
    st.wdSel       = WD_DATA;
    memReq         = 1'b0;
    memWe          = 1'b0;
    devAck         = 1'b0;
    devStoreStatus = 1'b0;
    case (state)
      S_FETCH: begin
        memReq     = 1'b1;
        st.entOfs  = ofs;
        st.fetchLd = memRdy;
      end
      S_DEC: begin
        if (entKind == ENT_LINK)     st.linkLd = 1'b1;
        else if (entKind != ENT_END) st.bufLd  = 1'b1;
      end
      S_WAIT: begin
        if (devReq && !dir) begin
          devAck    = 1'b1;
          st.devCap = 1'b1;
        end
      end
      S_MEMX: begin
        memReq      = 1'b1;
        memWe       = !dir;
        st.addrSel  = ASEL_BUF;
        st.byteStep = memRdy;
        st.outLd    = memRdy && dir;
      end
      S_POST: devAck = dir;
      S_WLEN0: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.entOfs = OFS_LENLO;
        st.wdSel  = WD_LENLO;
      end
      S_WLEN1: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.entOfs = OFS_LENHI;
        st.wdSel  = WD_LENHI;
      end
      S_WSTAT: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        st.entOfs      = OFS_STAT;
        st.wdSel       = withStat ? WD_STAT : WD_DONE;
        devStoreStatus = withStat;
        st.larStep     = memRdy;
        st.irqSet      = memRdy && irqWanted;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      ofs      <= '0;
      termF    <= 1'b0;
      withStat <= 1'b0;
      active   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          state  <= S_FETCH;
          ofs    <= '0;
          active <= 1'b1;
        end
        S_FETCH: if (memRdy) begin
          ofs <= ofs + 1'b1;
          if (ofs == 3'd7) state <= S_DEC;
        end
        S_DEC: begin
          termF    <= 1'b0;
          withStat <= 1'b0;
          ofs      <= '0;
          case (entKind)
            ENT_LINK: state <= S_FETCH;
            ENT_END: begin
              state  <= S_IDLE;
              active <= 1'b0;
            end
            default: state <= entLenZero ? S_WSTAT : S_WAIT;
          endcase
        end
        S_WAIT: begin
          if (devReq) begin
            termF <= devTerm;
            state <= S_MEMX;
          end else if (devTerm) begin
            withStat <= 1'b1;
            state    <= S_WLEN0;
          end
        end
        S_MEMX: if (memRdy) state <= S_POST;
        S_POST: begin
          if (termF) begin
            withStat <= 1'b1;
            state    <= S_WLEN0;
          end else if (lenZero) state <= S_WSTAT;
          else                  state <= S_WAIT;
        end
        S_WLEN0: if (memRdy) state <= S_WLEN1;
        S_WLEN1: if (memRdy) state <= S_WSTAT;
        S_WSTAT: if (memRdy) begin
          ofs   <= '0;
          state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memRdy,
  input  logic              devReq,
  input  logic              devTerm,
  input  logic [7:0]        devDin,
  output logic              devAck,
  output logic [7:0]        devDout,
  output logic              devStoreStatus
);
  strobe_t    st;
  logic       active;
  logic       startReq;
  entKind_t   entKind;
  logic       entLenZero;
  logic       lenZero;
  logic [1:0] ie;
  logic       dir;

  lldma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memRdy(memRdy),
    .devReq(devReq), .devTerm(devTerm), .entKind(entKind),
    .entLenZero(entLenZero), .lenZero(lenZero), .ie(ie), .dir(dir),
    .st(st), .memReq(memReq), .memWe(memWe), .devAck(devAck),
    .devStoreStatus(devStoreStatus), .active(active)
  );

  lldma_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .active(active), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .devDin(devDin), .devDout(devDout), .startReq(startReq),
    .entKind(entKind), .entLenZero(entLenZero), .lenZero(lenZero),
    .ie(ie), .dir(dir), .irq(irq)
  );

endmodule

// File: rtl/lldma_chan_chk.sv
module lldma_chan_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [1:0]        regAddr,
  input logic [7:0]        regWdata,
  input logic [7:0]        regRdata,
  input logic              irq,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdy,
  input logic [7:0]        memWdata,
  input logic              devStoreStatus
);
  // R1
  lar_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdata[2:0] == 3'b100));

  // R6
  store_status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    devStoreStatus |-> (memReq && memWe && memAddr[2:0] == 3'd4 && memWdata[7:6] == 2'b11));

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R10
  irq_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWr && regAddr == 2'd3 && regWdata[7]));

  // R8
  irq_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memReq && memRdy && memWe && memAddr[2:0] == 3'd4));

endmodule

bind lldma_chan lldma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_lldma_chan.sv
module test_lldma_chan;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [7:0]    regWdata = 8'd0;
  logic [7:0]    regRdata;
  logic          irq;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata, memRdata;
  logic          memRdy;
  logic          devReq = 1'b0, devTerm = 1'b0;
  logic [7:0]    devDin = 8'd0;
  logic          devAck, devStoreStatus;
  logic [7:0]    devDout;

  logic [7:0] mem [0:1023];
  logic       stallTog = 1'b0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign memRdata = mem[memAddr[9:0]];
  assign memRdy   = memReq && stallTog;

  always @(posedge clk) begin
    if (memReq) stallTog <= ~stallTog;
    if (memReq && memRdy && memWe) mem[memAddr[9:0]] <= memWdata;
  end

  lldma_chan #(.ADDR_W(AW)) i_lldma_chan (.*);

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regRead(2'd3, v);
      if (!v[6]) break;
    end
  endtask

  task automatic putEntry(input int base, input int kind, input int bufA, input int len);
    mem[base]   = bufA[7:0];
    mem[base+1] = bufA[15:8];
    mem[base+2] = bufA[23:16];
    mem[base+3] = 8'h00;
    mem[base+4] = 8'(kind);
    mem[base+5] = 8'h00;
    mem[base+6] = len[7:0];
    mem[base+7] = len[15:8];
  endtask

  task automatic startAt(input int addr);
    regWrite(2'd0, addr[7:0]);
    regWrite(2'd1, addr[15:8]);
    regWrite(2'd2, addr[23:16]);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit t);
    @(negedge clk);
    devReq = 1'b1; devDin = v; devTerm = t;
    #1;
    while (!devAck) begin @(negedge clk); #1; end
    @(negedge clk);
    devReq = 1'b0; devTerm = 1'b0;
  endtask

  // kind 0: count runs out, 1: terminate with last byte, 2: terminate with no byte
  task automatic runOne(input int ie, input int typ, input int kind, input bit collide);
    logic [7:0] vals [3];
    logic [5:0] stv;
    int len, sent, expLen, expIrq, expStat;
    string tag;
    logic [7:0] v;
    len  = (kind == 0) ? 3 : 16'h0105;
    stv  = 6'((ie * 12 + typ * 5 + kind + 1) % 64);
    for (int i = 0; i < 3; i++) vals[i] = 8'((ie * 8 + typ * 4 + kind + i) ^ 8'hA5);
    for (int i = 0; i < 16; i++) mem[16'h200 + i] = 8'h00;
    putEntry(16'h100, typ, 16'h200, len);
    putEntry(16'h108, 3, 0, 0);
    regWrite(2'd3, 8'h80 | 8'(ie));
    startAt(16'h100);
    case (kind)
      0: begin
        for (int i = 0; i < 3; i++) sendByte(vals[i], 1'b0);
        if (collide) begin
          for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (memReq && memWe && memRdy && memAddr[9:0] == 10'h104) begin
              regAddr = 2'd3; regWdata = 8'h80 | 8'(ie); regWr = 1'b1;
              @(negedge clk);
              regWr = 1'b0;
              break;
            end
          end
        end
        sent = 3;
      end
      1: begin
        sendByte(vals[0], 1'b0);
        sendByte(vals[1], 1'b1);
        devDin = {2'b00, stv};
        sent = 2;
      end
      default: begin
        @(negedge clk);
        devTerm = 1'b1; devDin = {2'b00, stv};
        for (int i = 0; i < 1000; i++) begin
          #1;
          if (devStoreStatus) break;
          @(negedge clk);
        end
        @(negedge clk);
        devTerm = 1'b0;
        sent = 0;
      end
    endcase
    waitIdle();
    $sformat(tag, "ie=%0d typ=%0d kind=%0d", ie, typ, kind);
    for (int i = 0; i < sent; i++)
      check({"R3 data ", tag}, int'(mem[16'h200 + i]), int'(vals[i]));
    check({"R3 untouched ", tag}, int'(mem[16'h200 + sent]), 0);
    expLen  = len - sent;
    expStat = (kind == 0) ? 8'h80 : (8'hC0 | int'(stv));
    if (kind == 0) expIrq = ((ie >= 2) || (ie == 1 && typ == 1)) ? 1 : 0;
    else           expIrq = (ie != 0) ? 1 : 0;
    if (kind == 0) check({"R4 done byte ", tag}, int'(mem[16'h104]), expStat);
    else           check({"R6 status byte ", tag}, int'(mem[16'h104]), expStat);
    if (kind == 1) check({"R7 residual ", tag}, int'({mem[16'h107], mem[16'h106]}), expLen);
    else           check({"R6 residual ", tag}, int'({mem[16'h107], mem[16'h106]}), kind == 0 ? len : expLen);
    if (collide) check({"R10 set wins ", tag}, int'(irq), 1);
    else if (kind == 0) check({"R8 irq ", tag}, int'(irq), expIrq);
    else check({"R9 irq ", tag}, int'(irq), expIrq);
    regRead(2'd0, v);
    check({"R11 end pointer ", tag}, int'(v), 8'h0C);
  endtask

  initial begin
    logic [7:0] v, g;
    logic [7:0] got [4];
    int cnt;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(2'd0, v); check("R1 reset low byte", int'(v), 8'h04);
    regRead(2'd3, v); check("R2 reset csr", int'(v), 0);
    check("R10 reset irq", int'(irq), 0);

    // R1: pointer write drops low bits
    regWrite(2'd0, 8'hFB);
    regWrite(2'd1, 8'h12);
    regRead(2'd0, v); check("R1 low bits", int'(v), 8'hFC);
    regRead(2'd1, v); check("R1 mid byte", int'(v), 8'h12);

    // sweep: interrupt enable x buffer kind x ending
    for (int ie = 0; ie < 4; ie++)
      for (int typ = 0; typ < 2; typ++)
        for (int kind = 0; kind < 3; kind++)
          runOne(ie, typ, kind, 1'b0);

    // R10: set and clear in the same cycle
    runOne(2, 0, 0, 1'b1);
    regWrite(2'd3, 8'h82);
    check("R10 clear", int'(irq), 0);

    // R5: zero-length buffer
    putEntry(16'h100, 0, 16'h200, 0);
    putEntry(16'h108, 3, 0, 0);
    mem[16'h200] = 8'h00;
    regWrite(2'd3, 8'h82);
    startAt(16'h100);
    waitIdle();
    check("R5 done byte", int'(mem[16'h104]), 8'h80);
    check("R5 irq", int'(irq), 1);
    check("R5 no data", int'(mem[16'h200]), 0);

    // R13, R11, R2: memory to peripheral through a link
    for (int i = 0; i < 4; i++) mem[16'h300 + i] = 8'(8'h5A + 8'(i * 7));
    putEntry(16'h100, 0, 16'h300, 4);
    putEntry(16'h108, 2, 16'h180, 0);
    putEntry(16'h180, 3, 0, 0);
    regWrite(2'd3, 8'h86);
    startAt(16'h100);
    repeat (40) @(negedge clk);
    regRead(2'd3, v); check("R2 active", int'(v[6]), 1);
    regWrite(2'd2, 8'h3F);
    regWrite(2'd1, 8'h55);
    regRead(2'd1, v); check("R2 ignored mid", int'(v), 8'h01);
    regRead(2'd2, v); check("R2 ignored high", int'(v), 8'h00);
    cnt = 0;
    devReq = 1'b1;
    for (int i = 0; i < 2000 && cnt < 4; i++) begin
      @(negedge clk);
      #1;
      if (devAck) begin
        got[cnt] = devDout;
        cnt++;
        if (cnt == 4) devReq = 1'b0;
      end
    end
    devReq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      g = 8'(8'h5A + 8'(i * 7));
      check("R13 byte out", int'(got[i]), int'(g));
    end
    waitIdle();
    check("R13 done byte", int'(mem[16'h104]), 8'h80);
    check("R8 irq all", int'(irq), 1);
    regRead(2'd0, v); check("R11 link low", int'(v), 8'h84);
    regRead(2'd1, v); check("R11 link mid", int'(v), 8'h01);
    regRead(2'd3, v); check("R11 idle", int'(v[6]), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule